// File: doc/BRIEF.md
# Cascaded Programmable Clock Channel Divider

This block divides one clock into a slower output clock for a single output channel. It has two divide stages in series. The second stage advances on each rising edge of the first stage's output, so the overall period is the product of the two stage periods. Each stage takes its own high-time count, low-time count, phase-offset count and starting level. Each stage can also be bypassed, in which case its input passes straight through and its counter stands still.

A shared synchronisation strobe puts both stages into a known state. While the strobe is high, each stage holds its output at its start level and captures its configuration. When the strobe falls, each stage waits for its phase offset in input cycles and then runs its start-level phase. A channel setting makes the channel ignore the strobe. In that mode new counts are picked up at each falling output edge. In the same mode a force option can hold the output high.

Top module: `clkdiv_chain`

## Requirements
- R1: When a stage runs and is not bypassed, its output stays low for (low count + 1) of its input cycles.
- R2: When a stage runs and is not bypassed, its output stays high for (high count + 1) of its input cycles.
- R3: After an obeyed sync strobe falls, each stage stays at its start level for (phase count + start-phase count + 1) of its input cycles before it first changes.
- R4: A bypassed stage passes its input to its output and its counter stays idle. With both stages bypassed, the output follows the input clock (high while clk is high, low while clk is low).
- R5: While sync is high and obeyed, each non-bypassed stage drives its start level (start bit 1 = high, 0 = low) from the clock edge after sync is first sampled high.
- R6: When the ignore-sync bit is set, the sync input has no effect and the output keeps dividing.
- R7: With the ignore-sync bit and the force bit both set, the output is high. When ignore-sync is clear, the force bit has no effect.
- R8: The second stage's input cycles are the rising edges of the first stage's output. When the first stage is bypassed, they are every clk cycle.
- R9: While sync is obeyed, count changes take effect only at the next sync. While sync is ignored, they take effect at the stage's next falling output edge.
- R10: During reset the output is low and all captured counts are zero. After reset the channel divides clk by 4, starting with a rise on the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronisation strobe, level sensitive |
| nosync_i | input | 1 | 1 = ignore sync for this channel |
| force_hi_i | input | 1 | Force the output high (only while nosync_i = 1) |
| s1_hi_i | input | CW | Stage 1 high count (high time minus one) |
| s1_lo_i | input | CW | Stage 1 low count (low time minus one) |
| s1_ph_i | input | CW | Stage 1 phase offset in input cycles |
| s1_start_i | input | 1 | Stage 1 start level |
| s1_byp_i | input | 1 | Stage 1 bypass |
| s2_hi_i | input | CW | Stage 2 high count |
| s2_lo_i | input | CW | Stage 2 low count |
| s2_ph_i | input | CW | Stage 2 phase offset in stage-2 input cycles |
| s2_start_i | input | 1 | Stage 2 start level |
| s2_byp_i | input | 1 | Stage 2 bypass |
| div_clk_o | output | 1 | Divided channel clock |

## Verification
The bench builds the block with its default count width of four bits. This lets every count and offset field reach its largest value of fifteen. At that setting one vector gives 16-cycle phases, 31-cycle start delays and a channel period of 1024 clk cycles, which the vector table walks past. With the narrow width the bench can also cover pass-through of either stage, start-high in each stage, and period-boundary reloads in a few hundred cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W_DEF = 4;

  // Count loaded for the first phase after sync: chooses high or low length.
  function automatic int first_count(int hi, int lo, bit start_hi);
    return start_hi ? hi : lo;
  endfunction

  // Delay before the first toggle after sync: offset plus first phase count.
  function automatic int lead_ticks(int ph, int cnt);
    return ph + cnt;
  endfunction
endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          hold_i,
  input  logic          reload_i,
  input  logic          byp_i,
  input  logic          start_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] ph_i,
  output logic          lvl_o,
  output logic          rise_o
);
  localparam int CNTW = CW + 1;

  logic [CNTW-1:0] cnt_q;
  logic [CW-1:0]   sh_hi_q;
  logic [CW-1:0]   sh_lo_q;
  logic            lvl_q;
  logic            run_w;
  logic            expire_w;
  logic            fall_w;

  assign run_w    = adv_i & ~hold_i & ~byp_i;
  assign expire_w = run_w & (cnt_q == '0);
  assign rise_o   = expire_w & ~lvl_q;
  assign fall_w   = expire_w & lvl_q;
  assign lvl_o    = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_hi_q <= '0;
      sh_lo_q <= '0;
      lvl_q   <= 1'b0;
    end else if (!byp_i) begin
      if (hold_i) begin
        sh_hi_q <= hi_i;
        sh_lo_q <= lo_i;
        lvl_q   <= start_i;
        cnt_q   <= CNTW'(clkdiv_pkg::lead_ticks(int'(ph_i),
                     clkdiv_pkg::first_count(int'(hi_i), int'(lo_i), start_i)));
      end else if (rise_o) begin
        lvl_q <= 1'b1;
        cnt_q <= CNTW'(sh_hi_q);
      end else if (fall_w) begin
        lvl_q <= 1'b0;
        if (reload_i) begin
          sh_hi_q <= hi_i;
          sh_lo_q <= lo_i;
          cnt_q   <= CNTW'(lo_i);
        end else begin
          cnt_q <= CNTW'(sh_lo_q);
        end
      end else if (run_w) begin
        cnt_q <= cnt_q - CNTW'(1);
      end
    end
  end
endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel (
  input  logic clk,
  input  logic lvl1_i,
  input  logic lvl2_i,
  input  logic byp1_i,
  input  logic byp2_i,
  input  logic force_i,
  output logic out_o
);
  always_comb begin
    if (force_i)     out_o = 1'b1;
    else if (byp2_i) out_o = byp1_i ? clk : lvl1_i;
    else             out_o = lvl2_i;
  end
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain #(
  parameter int CW = clkdiv_pkg::CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          nosync_i,
  input  logic          force_hi_i,
  input  logic [CW-1:0] s1_hi_i,
  input  logic [CW-1:0] s1_lo_i,
  input  logic [CW-1:0] s1_ph_i,
  input  logic          s1_start_i,
  input  logic          s1_byp_i,
  input  logic [CW-1:0] s2_hi_i,
  input  logic [CW-1:0] s2_lo_i,
  input  logic [CW-1:0] s2_ph_i,
  input  logic          s2_start_i,
  input  logic          s2_byp_i,
  output logic          div_clk_o
);
  localparam int NSTG = 2;

  logic [CW-1:0]   hi_a [NSTG];
  logic [CW-1:0]   lo_a [NSTG];
  logic [CW-1:0]   ph_a [NSTG];
  logic [NSTG-1:0] st_a, byp_a, adv_a, lvl_a, rise_a;

  // Named events for the checker.
  logic hold_w, force_w, s1_lvl_w, s2_lvl_w, s1_rise_w, s2_rise_w;

  assign hold_w  = sync_i & ~nosync_i;
  assign force_w = force_hi_i & nosync_i;

  assign hi_a[0] = s1_hi_i;  assign hi_a[1] = s2_hi_i;
  assign lo_a[0] = s1_lo_i;  assign lo_a[1] = s2_lo_i;
  assign ph_a[0] = s1_ph_i;  assign ph_a[1] = s2_ph_i;
  assign st_a    = {s2_start_i, s1_start_i};
  assign byp_a   = {s2_byp_i, s1_byp_i};
  assign adv_a[0] = 1'b1;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    if (g > 0) begin : g_chain
      assign adv_a[g] = byp_a[g-1] | rise_a[g-1];
    end
    clkdiv_stage #(.CW(CW)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_i    (adv_a[g]),
      .hold_i   (hold_w),
      .reload_i (nosync_i),
      .byp_i    (byp_a[g]),
      .start_i  (st_a[g]),
      .hi_i     (hi_a[g]),
      .lo_i     (lo_a[g]),
      .ph_i     (ph_a[g]),
      .lvl_o    (lvl_a[g]),
      .rise_o   (rise_a[g])
    );
  end

  assign s1_lvl_w  = lvl_a[0];
  assign s2_lvl_w  = lvl_a[1];
  assign s1_rise_w = rise_a[0];
  assign s2_rise_w = rise_a[1];

  clkdiv_outsel u_outsel (
    .clk     (clk),
    .lvl1_i  (s1_lvl_w),
    .lvl2_i  (s2_lvl_w),
    .byp1_i  (s1_byp_i),
    .byp2_i  (s2_byp_i),
    .force_i (force_w),
    .out_o   (div_clk_o)
  );
endmodule

// File: rtl/clkdiv_chain_chk.sv
module clkdiv_chain_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_w,
  input logic force_w,
  input logic s1_start_i,
  input logic s2_start_i,
  input logic s1_byp_i,
  input logic s2_byp_i,
  input logic s1_lvl_w,
  input logic s2_lvl_w,
  input logic s1_rise_w,
  input logic s2_rise_w,
  input logic div_clk_o
);
  p_start_s1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && !s1_byp_i) |=> (s1_lvl_w == $past(s1_start_i)));

  p_start_s2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && !s2_byp_i) |=> (s2_lvl_w == $past(s2_start_i)));

  p_byp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s1_byp_i) |-> $stable(s1_lvl_w));

  p_cascade_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold_w) && !$past(s1_byp_i) && !$past(s2_byp_i) && !$stable(s2_lvl_w))
      |-> $past(s1_rise_w));

  p_rise_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_rise_w && !s1_byp_i) |-> s1_rise_w);

  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_w |-> div_clk_o);
endmodule

bind clkdiv_chain clkdiv_chain_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold_w     (hold_w),
  .force_w    (force_w),
  .s1_start_i (s1_start_i),
  .s2_start_i (s2_start_i),
  .s1_byp_i   (s1_byp_i),
  .s2_byp_i   (s2_byp_i),
  .s1_lvl_w   (s1_lvl_w),
  .s2_lvl_w   (s2_lvl_w),
  .s1_rise_w  (s1_rise_w),
  .s2_rise_w  (s2_rise_w),
  .div_clk_o  (div_clk_o)
);

// File: tb/clkdiv_chain_tb.sv
module clkdiv_chain_tb;
  localparam int CW = 4;
  localparam int NV = 6;
  localparam int NS = 2500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, nosync_i = 1'b0, force_hi_i = 1'b0;
  logic [CW-1:0] s1_hi_i = '0, s1_lo_i = '0, s1_ph_i = '0;
  logic [CW-1:0] s2_hi_i = '0, s2_lo_i = '0, s2_ph_i = '0;
  logic s1_start_i = 1'b0, s1_byp_i = 1'b0, s2_start_i = 1'b0, s2_byp_i = 1'b0;
  logic div_clk_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkdiv_chain #(.CW(CW)) u_dut (.*);

  // {hi1,lo1,ph1,st1,by1,hi2,lo2,ph2,st2,by2}
  localparam logic [27:0] TBL [NV] = '{
    {4'd0,  4'd0,  4'd0,  1'b0, 1'b0, 4'd0,  4'd0,  4'd0,  1'b0, 1'b0},
    {4'd2,  4'd1,  4'd3,  1'b0, 1'b0, 4'd1,  4'd0,  4'd1,  1'b1, 1'b0},
    {4'd0,  4'd4,  4'd0,  1'b1, 1'b0, 4'd0,  4'd0,  4'd0,  1'b0, 1'b1},
    {4'd0,  4'd0,  4'd0,  1'b0, 1'b1, 4'd3,  4'd2,  4'd2,  1'b0, 1'b0},
    {4'd15, 4'd15, 4'd15, 1'b1, 1'b0, 4'd15, 4'd15, 4'd15, 1'b0, 1'b0},
    {4'd1,  4'd3,  4'd5,  1'b1, 1'b0, 4'd0,  4'd2,  4'd0,  1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Independent waveform model: level at index n after sync release.
  function automatic bit mdl(int n, int p, int a, int b, bit s);
    if (n < p + a) return s;
    return (((n - p - a) % (a + b)) < b) ? ~s : s;
  endfunction

  task automatic count_rises(input int n, output int r);
    bit prev = div_clk_o;
    r = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_clk_o && !prev) r++;
      prev = div_clk_o;
    end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_clk_o) h++;
    end
  endtask

  task automatic sync_pulse();
    sync_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic load_vec(input logic [27:0] v);
    {s1_hi_i, s1_lo_i, s1_ph_i, s1_start_i, s1_byp_i,
     s2_hi_i, s2_lo_i, s2_ph_i, s2_start_i, s2_byp_i} = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R10 act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r, h;
    // R10: reset state and default division
    repeat (3) @(negedge clk);
    chk(div_clk_o == 1'b0, "R10 low in reset", div_clk_o, 0);
    rst_n = 1'b1;
    count_rises(40, r);
    chk(r == 10, "R10 default div4 rises", r, 10);

    // Vector table: R1 R2 R3 R5 R8 (and R4 single-stage bypass)
    for (int v = 0; v < NV; v++) begin
      int p1, a1, b1, p2, a2, b2, rc, mism, fa, fe, fi;
      bit s1, s2, l1, l1p, e, by1, by2;
      load_vec(TBL[v]);
      nosync_i = 1'b0; force_hi_i = 1'b0;
      p1 = int'(s1_ph_i); s1 = s1_start_i; by1 = s1_byp_i;
      a1 = (s1 ? int'(s1_hi_i) : int'(s1_lo_i)) + 1;
      b1 = (s1 ? int'(s1_lo_i) : int'(s1_hi_i)) + 1;
      p2 = int'(s2_ph_i); s2 = s2_start_i; by2 = s2_byp_i;
      a2 = (s2 ? int'(s2_hi_i) : int'(s2_lo_i)) + 1;
      b2 = (s2 ? int'(s2_lo_i) : int'(s2_hi_i)) + 1;
      sync_pulse();
      rc = 0; mism = 0; fa = 0; fe = 0; fi = -1; l1p = 1'b0;
      for (int n = 0; n < NS; n++) begin
        l1 = mdl(n, p1, a1, b1, s1);
        if (by1) rc = n;
        else if (n > 0 && l1 && !l1p) rc++;
        l1p = l1;
        e = by2 ? l1 : mdl(rc, p2, a2, b2, s2);
        if (div_clk_o !== e) begin
          if (mism == 0) begin fa = int'(div_clk_o); fe = int'(e); fi = n; end
          mism++;
        end
        @(negedge clk);
      end
      if (mism != 0) $display("  vector %0d first mismatch at index %0d", v, fi);
      chk(mism == 0, $sformatf("R1 R2 R3 R4 R5 R8 vector %0d", v), fa, fe);
    end

    // R4: both stages bypassed, output follows clk
    s1_byp_i = 1'b1; s2_byp_i = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #5;
      chk(div_clk_o == 1'b1, "R4 bypass high phase", div_clk_o, 1);
      @(negedge clk); #1;
      chk(div_clk_o == 1'b0, "R4 bypass low phase", div_clk_o, 0);
    end
    @(negedge clk);

    // Base config: all counts zero, no bypass (div4)
    load_vec(TBL[0]);
    sync_pulse();

    // R6: sync ignored while nosync set
    nosync_i = 1'b1;
    sync_i = 1'b1;
    count_rises(20, r);
    chk(r == 5, "R6 sync ignored", r, 5);
    // R5: obeyed sync freezes the output
    nosync_i = 1'b0;
    @(negedge clk); @(negedge clk);
    count_rises(20, r);
    chk(r == 0, "R5 held by sync", r, 0);
    sync_i = 1'b0;
    @(negedge clk);

    // R7: force gating
    nosync_i = 1'b1; force_hi_i = 1'b1;
    count_high(20, h);
    chk(h == 20, "R7 forced high", h, 20);
    nosync_i = 1'b0;
    sync_pulse();
    count_rises(20, r);
    chk(r == 5, "R7 force ignored without nosync", r, 5);
    force_hi_i = 1'b0;

    // R9: reload rules (stage 2 bypassed, stage 1 div2)
    s2_byp_i = 1'b1;
    sync_pulse();
    s1_hi_i = 4'd3;
    @(negedge clk);
    count_high(40, h);
    chk(h == 20, "R9 no reload without sync", h, 20);
    nosync_i = 1'b1;
    repeat (10) @(negedge clk);
    count_high(50, h);
    chk(h == 40, "R9 reload at falling edge when sync ignored", h, 40);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule